// File: doc/BRIEF.md
# Overcurrent Fault Timer

This block times overcurrent events for one switched power channel. Two digitised comparator flags come in: a soft current-limit flag, raised while the channel is actively limiting current, and a circuit-breaker flag, raised while the current is above the breaker level. A flag counts only once it has stayed high for a short qualification window. Each qualified flag feeds its own integrating counter. Each counter has its own timeout, given in clock ticks, which is either taken from an input or set to a built-in default.

The two counters rise at the same rate but fall at different rates. The current-limit counter falls by one step per 128 ticks, so a string of short overloads can add up to a trip. The breaker counter falls by one step per tick, so it trips only on a sustained excess. When either counter reaches its timeout, the block raises a gate-off request and pulls its active-low fault output low. In retry mode the channel restarts on its own after 128 times the timeout that tripped. In latch mode the channel stays off until the channel enable is dropped and raised again. The reset is asynchronous, and its release must be synchronous to the clock.

Top module: `ocp_fault_timer`

## Requirements
- R1: While reset is asserted, and in the cycle after any cycle with `chan_en_i` low, `gate_off_o` is 0 and `fault_n_o` is 1, and both counters are zero.
- R2: A raw flag counts only after it has been sampled high on QUAL_CYC consecutive clock edges. A pulse shorter than that never advances a counter.
- R3: The current-limit counter rises by one on each tick its qualified flag is true. While the flag is false it falls by one every 128 ticks, never below zero. Repeated short overloads can therefore accumulate to a trip.
- R4: The breaker counter rises by one on each tick its qualified flag is true and falls by one on each tick it is false, never below zero.
- R5: A flag is first sampled high at clock edge 1 and then held high, with timeout T. `gate_off_o` rises and `fault_n_o` falls right after edge QUAL_CYC+T. Both outputs then hold until the channel restarts.
- R6: The effective timeout is DFLT_CL (current limit) or DFLT_CB (breaker) while the timer's default select is 1. Otherwise it is the timeout input, and a value of 0 is treated as 1.
- R7: In retry mode (`retry_i`=1), `gate_off_o` stays high for exactly 128×T cycles, where T is the effective timeout of the timer that tripped. The channel then restarts with `fault_n_o` released and both counters at zero.
- R8: In latch mode (`retry_i`=0), a tripped channel stays off with the fault output low for as long as `chan_en_i` stays high.
- R9: If both counters reach their timeouts in the same cycle, the restart delay is 128 times the breaker timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cl_flag_i | input | 1 | Raw current-limit comparator flag |
| cb_flag_i | input | 1 | Raw circuit-breaker comparator flag |
| cl_tmo_i | input | TW | Programmed current-limit timeout in ticks |
| cb_tmo_i | input | TW | Programmed breaker timeout in ticks |
| cl_dflt_i | input | 1 | 1 selects the default current-limit timeout |
| cb_dflt_i | input | 1 | 1 selects the default breaker timeout |
| retry_i | input | 1 | 1 selects automatic restart, 0 selects latch-off |
| chan_en_i | input | 1 | Channel enable; low clears the timer and releases a latch |
| gate_off_o | output | 1 | Gate-off request to the channel's gate driver |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
Every cycle, the assertions check the following:
- the qualification filter blocks a flag that was just low;
- each counter takes exactly one step up on a non-tripping qualified tick;
- the breaker counter decays by one per idle tick;
- a hit always leads to a gate-off;
- a latched channel holds its state;
- a disable releases the outputs;
- a simultaneous trip captures the breaker timeout.

Only the bench scenarios can show the end-to-end timing. This covers the trip instant measured from the first raw sample, the exact length of the restart delay for each timer, and accumulation across widely spaced overloads with the 1/128 decay. It also covers the contrast between the two decay rates under the same pulse train.

// File: rtl/ocp_fault_pkg.sv
package ocp_fault_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_OFF = 1'b1
  } ocp_state_e;

  localparam int unsigned RESTART_SHIFT = 7;
  localparam int unsigned NUM_TIMERS    = 2;
  localparam int unsigned IDX_CL        = 0;
  localparam int unsigned IDX_CB        = 1;
endpackage

// File: rtl/ocp_flag_qual.sv
module ocp_flag_qual #(
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic qual_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] run_q, run_d;

  always_comb begin
    if (!raw_i)             run_d = '0;
    else if (run_q == QMAX) run_d = run_q;
    else                    run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign qual_o = (run_q == QMAX);

  // R2: a flag sampled low cannot be qualified in the following cycle
  p_glitch_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_i |=> !qual_o);
endmodule

// File: rtl/ocp_integrator.sv
module ocp_integrator #(
  parameter int unsigned CW        = 16,
  parameter int unsigned DECAY_DIV = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          up_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] acc_q, acc_d;
  logic [CW:0]   acc_inc;
  logic [CW-1:0] acc_dec;
  logic          decay_tick;

  assign acc_inc = {1'b0, acc_q} + 1'b1;
  assign acc_dec = (acc_q == '0) ? '0 : acc_q - 1'b1;
  assign hit_o   = !clr_i && up_i && (acc_inc >= {1'b0, limit_i});

  generate
    if (DECAY_DIV > 1) begin : g_slow_decay
      localparam int unsigned DVW = $clog2(DECAY_DIV);
      localparam logic [DVW-1:0] DLAST = DVW'(DECAY_DIV - 1);
      logic [DVW-1:0] div_q, div_d;

      always_comb begin
        if (clr_i || up_i)       div_d = '0;
        else if (div_q == DLAST) div_d = '0;
        else                     div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign decay_tick = (div_q == DLAST);
    end else begin : g_fast_decay
      assign decay_tick = 1'b1;

      // R4: an idle breaker counter falls by exactly one per tick
      p_fast_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !up_i && acc_q != '0) |=> acc_q == $past(acc_q) - 1'b1);
    end
  endgenerate

  always_comb begin
    if (clr_i)           acc_d = '0;
    else if (up_i)       acc_d = hit_o ? acc_q : acc_inc[CW-1:0];
    else if (decay_tick) acc_d = acc_dec;
    else                 acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3 (and R4): a qualified tick that does not trip adds exactly one
  p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && up_i && !hit_o) |=> acc_q == $past(acc_q) + 1'b1);

  // R1: a clear leaves the counter at zero
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == '0);
endmodule

// File: rtl/ocp_trip_ctl.sv
module ocp_trip_ctl
  import ocp_fault_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          retry_i,
  input  logic          hit_cl_i,
  input  logic          hit_cb_i,
  input  logic [TW-1:0] tmo_cl_i,
  input  logic [TW-1:0] tmo_cb_i,
  output logic          clr_o,
  output logic          gate_off_o,
  output logic          fault_n_o
);
  localparam int unsigned DW = TW + RESTART_SHIFT;

  ocp_state_e    state_q, state_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic [DW-1:0] dly_q, dly_d;
  logic [DW-1:0] dly_end;

  assign dly_end = {tmo_q, {RESTART_SHIFT{1'b0}}} - 1'b1;

  always_comb begin
    state_d = state_q;
    tmo_d   = tmo_q;
    dly_d   = dly_q;
    if (!en_i) begin
      state_d = ST_RUN;
      dly_d   = '0;
    end else if (state_q == ST_RUN) begin
      if (hit_cl_i || hit_cb_i) begin
        state_d = ST_OFF;
        tmo_d   = hit_cb_i ? tmo_cb_i : tmo_cl_i;
        dly_d   = '0;
      end
    end else if (retry_i) begin
      if (dly_q == dly_end) begin
        state_d = ST_RUN;
        dly_d   = '0;
      end else begin
        dly_d   = dly_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      tmo_q   <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      dly_q   <= dly_d;
    end
  end

  assign clr_o      = !en_i || (state_q == ST_OFF);
  assign gate_off_o = (state_q == ST_OFF);
  assign fault_n_o  = (state_q != ST_OFF);

  // R5: a counter hit in a running channel always turns the gate off
  p_trip_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gate_off_o && (hit_cl_i || hit_cb_i)) |=> (gate_off_o && !fault_n_o));

  // R8: latch mode holds the channel off while enabled
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && gate_off_o && !retry_i) |=> gate_off_o);

  // R1: a disable releases the outputs
  p_disable_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_off_o && fault_n_o));

  // R9: a breaker hit decides the captured timeout
  p_cb_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gate_off_o && hit_cb_i) |=> tmo_q == $past(tmo_cb_i));
endmodule

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer
  import ocp_fault_pkg::*;
#(
  parameter int unsigned TW           = 16,
  parameter int unsigned QUAL_CYC     = 4,
  parameter int unsigned DFLT_CL      = 1000,
  parameter int unsigned DFLT_CB      = 3000,
  parameter int unsigned CL_DECAY_DIV = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cl_flag_i,
  input  logic          cb_flag_i,
  input  logic [TW-1:0] cl_tmo_i,
  input  logic [TW-1:0] cb_tmo_i,
  input  logic          cl_dflt_i,
  input  logic          cb_dflt_i,
  input  logic          retry_i,
  input  logic          chan_en_i,
  output logic          gate_off_o,
  output logic          fault_n_o
);
  logic [NUM_TIMERS-1:0] raw;
  logic [NUM_TIMERS-1:0] qual;
  logic [NUM_TIMERS-1:0] hit;
  logic [NUM_TIMERS-1:0] dflt;
  logic [TW-1:0]         prog [NUM_TIMERS];
  logic [TW-1:0]         lim  [NUM_TIMERS];
  logic                  clr;

  assign raw[IDX_CL]  = cl_flag_i;
  assign raw[IDX_CB]  = cb_flag_i;
  assign dflt[IDX_CL] = cl_dflt_i;
  assign dflt[IDX_CB] = cb_dflt_i;
  assign prog[IDX_CL] = cl_tmo_i;
  assign prog[IDX_CB] = cb_tmo_i;

  generate
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
      localparam logic [TW-1:0] DFLT_VAL = (i == IDX_CL) ? TW'(DFLT_CL) : TW'(DFLT_CB);
      localparam int unsigned   DIV      = (i == IDX_CL) ? CL_DECAY_DIV : 1;

      always_comb begin
        if (dflt[i])            lim[i] = DFLT_VAL;
        else if (prog[i] == '0) lim[i] = TW'(1);
        else                    lim[i] = prog[i];
      end

      ocp_flag_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw[i]),
        .qual_o (qual[i])
      );

      ocp_integrator #(.CW(TW), .DECAY_DIV(DIV)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .up_i    (qual[i]),
        .limit_i (lim[i]),
        .hit_o   (hit[i])
      );
    end
  endgenerate

  ocp_trip_ctl #(.TW(TW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (chan_en_i),
    .retry_i    (retry_i),
    .hit_cl_i   (hit[IDX_CL]),
    .hit_cb_i   (hit[IDX_CB]),
    .tmo_cl_i   (lim[IDX_CL]),
    .tmo_cb_i   (lim[IDX_CB]),
    .clr_o      (clr),
    .gate_off_o (gate_off_o),
    .fault_n_o  (fault_n_o)
  );
endmodule

// File: tb/ocp_fault_timer_bench.sv
module ocp_fault_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 8;
  localparam int Q    = 3;
  localparam int DCL  = 5;
  localparam int DCB  = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cl_flag, cb_flag, cl_dflt, cb_dflt, retry, en;
  logic [TW-1:0] cl_tmo, cb_tmo;
  logic          gate_off, fault_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit model_on = 1'b0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_timer #(.TW(TW), .QUAL_CYC(Q), .DFLT_CL(DCL), .DFLT_CB(DCB)) u_ocp_fault_timer (
    .clk(clk), .rst_n(rst_n), .cl_flag_i(cl_flag), .cb_flag_i(cb_flag),
    .cl_tmo_i(cl_tmo), .cb_tmo_i(cb_tmo), .cl_dflt_i(cl_dflt), .cb_dflt_i(cb_dflt),
    .retry_i(retry), .chan_en_i(en), .gate_off_o(gate_off), .fault_n_o(fault_n)
  );

  // ---- reference model built from the requirements ----
  int m_qcl, m_qcb, m_acl, m_acb, m_div, m_cap, m_dly;
  bit m_off;

  function automatic int eff_tmo(input bit d, input int p, input int dv);
    if (d) return dv;
    if (p == 0) return 1;
    return p;
  endfunction

  always @(posedge clk) begin
    bit qcl, qcb, hcl, hcb;
    int lcl, lcb;
    if (!rst_n) begin
      m_qcl = 0; m_qcb = 0; m_acl = 0; m_acb = 0; m_div = 0;
      m_off = 0; m_cap = 0; m_dly = 0;
    end else begin
      qcl = (m_qcl == Q); qcb = (m_qcb == Q);
      m_qcl = cl_flag ? ((m_qcl == Q) ? Q : m_qcl + 1) : 0;
      m_qcb = cb_flag ? ((m_qcb == Q) ? Q : m_qcb + 1) : 0;
      if (!en) begin
        m_acl = 0; m_acb = 0; m_div = 0; m_off = 0; m_dly = 0;
      end else if (m_off) begin
        m_acl = 0; m_acb = 0; m_div = 0;
        if (retry) begin
          if (m_dly == m_cap * 128 - 1) begin m_off = 0; m_dly = 0; end
          else m_dly++;
        end
      end else begin
        lcl = eff_tmo(cl_dflt, int'(cl_tmo), DCL);
        lcb = eff_tmo(cb_dflt, int'(cb_tmo), DCB);
        hcl = qcl && (m_acl + 1 >= lcl);
        hcb = qcb && (m_acb + 1 >= lcb);
        if (hcl || hcb) begin
          m_off = 1; m_cap = hcb ? lcb : lcl; m_dly = 0;
        end else begin
          if (qcl) begin m_acl++; m_div = 0; end
          else if (m_div == 127) begin m_div = 0; if (m_acl > 0) m_acl--; end
          else m_div++;
          if (qcb) m_acb++;
          else if (m_acb > 0) m_acb--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      n_checks++;
      if (gate_off !== m_off || fault_n !== !m_off) begin
        n_fail++;
        $display("FAIL R5 model compare: gate_off=%0b fault_n=%0b expected gate_off=%0b fault_n=%0b",
                 gate_off, fault_n, m_off, !m_off);
      end
    end
  end

  // ---- helpers ----
  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet_clear();
    cl_flag = 0; cb_flag = 0; en = 0;
    @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cycles_to_trip(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!gate_off && n < 5000);
  endtask

  task automatic off_duration(output int n);
    n = 1;
    cl_flag = 0; cb_flag = 0;
    @(negedge clk);
    while (gate_off && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulses(input bit use_cl, input int hi, input int lo, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      if (use_cl) cl_flag = 1; else cb_flag = 1;
      repeat (hi) @(negedge clk);
      cl_flag = 0; cb_flag = 0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 0; cl_flag = 0; cb_flag = 0; cl_dflt = 0; cb_dflt = 0;
    cl_tmo = 8'd6; cb_tmo = 8'd6; retry = 1; en = 1;
    repeat (3) @(negedge clk);
    check("R1 reset gate_off", gate_off, 0);
    check("R1 reset fault_n", fault_n, 1);
    rst_n = 1;
    @(negedge clk);
    model_on = 1;

    // R5: programmed current-limit timeout 6 -> trips after edge Q+6
    cl_flag = 1; cycles_to_trip(n);
    check("R5 cl trip cycle", n, Q + 6);
    check("R5 fault_n low at trip", fault_n, 0);
    // R7: restart after 128*6, fault released, counters cleared
    off_duration(n);
    check("R7 cl restart delay", n, 128 * 6);
    check("R7 fault released", fault_n, 1);
    cl_flag = 1; cycles_to_trip(n);
    check("R7 counter cleared on restart", n, Q + 6);
    off_duration(n);
    quiet_clear();

    // R6: defaults and zero clamp
    cl_dflt = 1; cl_flag = 1; cycles_to_trip(n);
    check("R6 default cl timeout", n, Q + DCL);
    off_duration(n);
    check("R7 default cl restart", n, 128 * DCL);
    cl_dflt = 0; quiet_clear();
    cl_tmo = 0; cl_flag = 1; cycles_to_trip(n);
    check("R6 zero timeout clamps to 1", n, Q + 1);
    quiet_clear();
    cb_dflt = 1; cb_flag = 1; cycles_to_trip(n);
    check("R6 default cb timeout", n, Q + DCB);
    off_duration(n);
    check("R7 cb restart delay", n, 128 * DCB);
    cb_dflt = 0; quiet_clear();

    // R9: breaker (8) and current limit (4) hit in the same cycle
    cl_tmo = 4; cb_tmo = 8;
    cb_flag = 1; repeat (4) @(negedge clk);
    cl_flag = 1; cycles_to_trip(n);
    check("R9 simultaneous trip cycle", n, Q + 4);
    off_duration(n);
    check("R9 breaker delay wins", n, 128 * 8);
    quiet_clear();

    // R2: pulses shorter than the qualification window never count
    cl_tmo = 1; cb_tmo = 1;
    for (int k = 0; k < 60; k++) begin
      cl_flag = 1; cb_flag = 1;
      repeat (Q - 1) @(negedge clk);
      cl_flag = 0; cb_flag = 0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check("R2 short pulses ignored", gate_off, 0);
    quiet_clear();

    // R3 vs R4: same pulse train, 2 counts per pulse, 20-tick gaps, timeout 3
    retry = 0; cl_tmo = 3; cb_tmo = 3;
    pulses(0, Q + 1, 20, 6);
    check("R4 breaker decays between pulses", gate_off, 0);
    quiet_clear();
    pulses(1, Q + 1, 20, 2);
    check("R3 current-limit accumulates to trip", gate_off, 1);
    quiet_clear();
    pulses(1, Q + 1, 300, 6);
    check("R3 slow decay drains long gaps", gate_off, 0);
    quiet_clear();

    // R8: latch mode holds until the enable toggles
    cl_tmo = 2; cl_flag = 1; cycles_to_trip(n);
    cl_flag = 0;
    repeat (1500) @(negedge clk);
    check("R8 latched gate_off", gate_off, 1);
    check("R8 latched fault_n", fault_n, 0);
    en = 0; @(negedge clk);
    check("R1 disable releases gate", gate_off, 0);
    check("R1 disable releases fault", fault_n, 1);
    en = 1; repeat (10) @(negedge clk);
    check("R8 restart after toggle", gate_off, 0);

    // random phase, checked by the model each cycle
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) begin
        cl_tmo = TW'($urandom % 16); cb_tmo = TW'($urandom % 16);
        cl_dflt = ($urandom % 5) == 0; cb_dflt = ($urandom % 5) == 0;
      end
      cl_flag = ($urandom % 100) < 40;
      cb_flag = ($urandom % 100) < 25;
      retry   = ($urandom % 100) < 95;
      en      = ($urandom % 300) != 0;
      @(negedge clk);
    end
    done = 1;
  end

  initial begin
    int w;
    w = 0;
    while (!done && w < 150000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule